// File: doc/BRIEF.md
# Encoder-Locked Slice Sequencer

This block picks which stored image slice a spinning projection screen should show. It counts encoder steps, splits each revolution into a fixed number of equal angular sectors, and moves a slice number forward each time the screen enters a new sector. The once-per-turn index mark pulls the slice number and the sector position back to zero. A loss of that mark is detected and flagged, and the count-based sequencing carries on without it.

Two frame buffers work in ping-pong fashion. The loader fills the back buffer with the slice that comes next while the front buffer is displayed. The block swaps the buffers only on a vertical-blank strobe, and only when a sector boundary is pending and the loader has finished. If a boundary arrives before the requested slice has been loaded, the block sets a sticky underrun flag and increments a saturating drop counter. A clear strobe resets all status.

Top module: `slice_sequencer`

## Requirements
- R1: A boundary occurs on every CPR/NSLICE-th `enc_step` pulse after the last zeroing. At each boundary `slice_num` advances by one and wraps from NSLICE-1 to 0, so a full revolution of CPR steps gives exactly NSLICE slice changes.
- R2: A rising edge on `enc_index` passes through two synchronizing flops and an edge detector. It then forces `slice_num` and the sector position to 0, and the next boundary follows CPR/NSLICE steps later.
- R3: After reset: `slice_num`=0, `front_sel`=0, `load_req`=1, `load_slice`=1, `underrun`=0, `drop_cnt`=0, `index_lost`=0.
- R4: `load_req` stays high until a cycle with `load_done` high, then falls. On the cycle after each buffer swap it rises again, with `load_slice` = (`slice_num`+1) mod NSLICE.
- R5: `front_sel` toggles only on a clock where `vblank` is high, a boundary is pending and the last request has completed. When the loader keeps up, each boundary produces exactly one swap.
- R6: A boundary that arrives while the last load request is still open sets `underrun` (sticky) and increments `drop_cnt` by one.
- R7: `drop_cnt` saturates at 2^DROP_W-1.
- R8: A `clr_status` pulse clears `underrun`, `drop_cnt` and `index_lost` on the next clock, and it takes priority over any set in that cycle.
- R9: When 2*CPR steps are counted with no index edge, `index_lost` is set (sticky). `slice_num` keeps advancing from the step count alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_step | input | 1 | One-cycle pulse per encoder count |
| enc_index | input | 1 | Once-per-revolution mark, asynchronous |
| vblank | input | 1 | Vertical-blank strobe from video timing |
| load_done | input | 1 | Loader reports back buffer filled |
| clr_status | input | 1 | Clears sticky status and drop counter |
| slice_num | output | $clog2(NSLICE) | Slice for the current screen angle |
| front_sel | output | 1 | Buffer currently displayed |
| load_req | output | 1 | Request to fill the back buffer |
| load_slice | output | $clog2(NSLICE) | Slice the loader must fetch |
| underrun | output | 1 | Sticky: boundary arrived before load completed |
| drop_cnt | output | DROP_W | Saturating count of missed boundaries |
| index_lost | output | 1 | Sticky: index mark missing for two revolutions |

## Verification
The hardest state to reach is an exact drop count. It needs a loader that never answers, a boundary left pending with no completed load, and the clear pulse placed between two steps so that the number of boundaries that follow is known. The bench gets there by switching its loader model off and waiting two sectors, which guarantees one swap and then an open request. It clears the status and steps through exact multiples of a sector until the counter saturates. Index loss is reached by withholding the mark for two revolutions while the scoreboard keeps following the slice numbers. Steps fall on even cycles and blanking on odd cycles, so a swap never shares a clock with a boundary.

// File: rtl/slice_sequencer.sv
module slice_sequencer #(
  parameter int CPR    = 240,
  parameter int NSLICE = 24,
  parameter int DROP_W = 8
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enc_step,
  input  logic                      enc_index,
  input  logic                      vblank,
  input  logic                      load_done,
  input  logic                      clr_status,
  output logic [$clog2(NSLICE)-1:0] slice_num,
  output logic                      front_sel,
  output logic                      load_req,
  output logic [$clog2(NSLICE)-1:0] load_slice,
  output logic                      underrun,
  output logic [DROP_W-1:0]         drop_cnt,
  output logic                      index_lost
);
  localparam int SW  = $clog2(NSLICE);
  localparam int SPC = CPR / NSLICE;
  localparam int PW  = $clog2(SPC + 1);
  localparam int LW  = $clog2(2 * CPR + 1);
  localparam logic [SW-1:0]     LAST     = SW'(NSLICE - 1);
  localparam logic [SW-1:0]     FIRST    = SW'(1 % NSLICE);
  localparam logic [PW-1:0]     SEG_LAST = PW'(SPC - 1);
  localparam logic [LW-1:0]     LOST_AT  = LW'(2 * CPR - 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [2:0]    idx_sh;
  logic [PW-1:0] seg;
  logic [LW-1:0] since;
  logic [SW-1:0] nxt;
  logic          idx_edge, bnd, swap, lost_hit, bnd_pend, ready;

  assign idx_edge = idx_sh[1] & ~idx_sh[2];
  assign bnd      = enc_step & ~idx_edge & (seg == SEG_LAST);
  assign nxt      = (slice_num == LAST) ? '0 : slice_num + 1'b1;
  assign swap     = vblank & bnd_pend & ready;
  assign lost_hit = enc_step & ~idx_edge & (since == LOST_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_sh    <= '0;
      seg       <= '0;
      slice_num <= '0;
      since     <= '0;
    end else begin
      idx_sh <= {idx_sh[1:0], enc_index};
      if (idx_edge) begin
        seg       <= '0;
        slice_num <= '0;
        since     <= '0;
      end else if (enc_step) begin
        if (since <= LOST_AT) since <= since + 1'b1;
        if (seg == SEG_LAST) begin
          seg       <= '0;
          slice_num <= nxt;
        end else begin
          seg <= seg + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_sel  <= 1'b0;
      load_req   <= 1'b1;
      load_slice <= FIRST;
      ready      <= 1'b0;
      bnd_pend   <= 1'b0;
    end else begin
      bnd_pend <= bnd | (bnd_pend & ~swap);
      if (swap) begin
        front_sel  <= ~front_sel;
        ready      <= 1'b0;
        load_req   <= 1'b1;
        load_slice <= nxt;
      end else if (load_req && load_done) begin
        load_req <= 1'b0;
        ready    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_status) begin
      underrun   <= 1'b0;
      drop_cnt   <= '0;
      index_lost <= 1'b0;
    end else begin
      if (bnd && !ready) begin
        underrun <= 1'b1;
        if (drop_cnt != DROP_MAX) drop_cnt <= drop_cnt + 1'b1;
      end
      if (lost_hit) index_lost <= 1'b1;
    end
  end
endmodule

// File: rtl/slice_sequencer_chk.sv
module slice_sequencer_chk #(
  parameter int NSLICE = 24,
  parameter int DROP_W = 8
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      vblank,
  input logic                      load_done,
  input logic                      clr_status,
  input logic                      idx_edge,
  input logic [$clog2(NSLICE)-1:0] slice_num,
  input logic                      front_sel,
  input logic                      load_req,
  input logic                      underrun,
  input logic [DROP_W-1:0]         drop_cnt,
  input logic                      index_lost
);
  localparam int SW = $clog2(NSLICE);

  // R1
  slice_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, slice_num} < (SW+1)'(NSLICE));

  // R2
  index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_edge |=> slice_num == '0);

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && load_done) |=> !load_req);

  // R5
  swap_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(front_sel));

  // R6
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr_status) |=> underrun);

  // R7
  drop_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> drop_cnt >= $past(drop_cnt));

  // R8
  clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> (!underrun && drop_cnt == '0 && !index_lost));
endmodule

bind slice_sequencer slice_sequencer_chk #(.NSLICE(NSLICE), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .load_done(load_done),
  .clr_status(clr_status), .idx_edge(idx_edge), .slice_num(slice_num),
  .front_sel(front_sel), .load_req(load_req), .underrun(underrun),
  .drop_cnt(drop_cnt), .index_lost(index_lost)
);

// File: tb/sim_slice_sequencer.sv
module sim_slice_sequencer;
  localparam int CPR = 240, NS = 24, SPC = 10, DW = 3;

  logic clk = 0, rst_n = 0;
  logic enc_step = 0, enc_index = 0, vblank = 0, clr_status = 0;
  logic ld_done_m = 0;
  logic [4:0] slice_num, load_slice;
  logic front_sel, load_req, underrun, index_lost;
  logic [DW-1:0] drop_cnt;

  slice_sequencer #(.CPR(CPR), .NSLICE(NS), .DROP_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_step(enc_step), .enc_index(enc_index),
    .vblank(vblank), .load_done(ld_done_m), .clr_status(clr_status),
    .slice_num(slice_num), .front_sel(front_sel), .load_req(load_req),
    .load_slice(load_slice), .underrun(underrun), .drop_cnt(drop_cnt),
    .index_lost(index_lost));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int exp_cnt = 0, exp_slice = 0;
  int exp_q[$];
  int chg_cnt = 0, swp_cnt = 0;
  int ld_delay = 3, wcnt = 0;
  bit ld_en = 1, idx_busy = 0, vb_at_edge = 0, done = 0;
  int prev_slice = 0;
  logic prev_front = 0, prev_req = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    vb_at_edge <= vblank;
  end

  // blanking strobe on odd cycles only; steps use even cycles
  always @(negedge clk) vblank = (cyc % 10 == 3);

  // loader model
  always @(negedge clk) begin
    ld_done_m = 0;
    if (!load_req) wcnt = 0;
    else if (ld_en) begin
      wcnt++;
      if (wcnt >= ld_delay) begin
        ld_done_m = 1;
        wcnt = 0;
      end
    end
  end

  // monitor: scoreboard of slice numbers, swap timing, load target
  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(slice_num) != prev_slice) begin
        chg_cnt++;
        if (exp_q.size() == 0) check(0, "R1 unexpected slice change", int'(slice_num), prev_slice);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(slice_num) == e, "R1 slice sequence", int'(slice_num), e);
        end
      end
      if (front_sel != prev_front) begin
        swp_cnt++;
        check(vb_at_edge, "R5 swap outside vblank", int'(vb_at_edge), 1);
      end
      if (load_req && !prev_req && !idx_busy)
        check(int'(load_slice) == (int'(slice_num) + 1) % NS, "R4 load target",
              int'(load_slice), (int'(slice_num) + 1) % NS);
      prev_slice = int'(slice_num);
      prev_front = front_sel;
      prev_req   = load_req;
    end
  end

  task automatic step();
    do @(negedge clk); while (cyc % 8 != 0);
    enc_step = 1;
    exp_cnt++;
    begin
      int s;
      s = (exp_cnt / SPC) % NS;
      if (s != exp_slice) exp_q.push_back(s);
      exp_slice = s;
    end
    @(negedge clk);
    enc_step = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic index_pulse();
    do @(negedge clk); while (cyc % 8 != 2);
    idx_busy = 1;
    enc_index = 1;
    exp_cnt = 0;
    if (exp_slice != 0) exp_q.push_back(0);
    exp_slice = 0;
    repeat (2) @(negedge clk);
    enc_index = 0;
    repeat (10) @(negedge clk);
    idx_busy = 0;
  endtask

  task automatic clear_pulse();
    do @(negedge clk); while (cyc % 8 != 4);
    clr_status = 1;
    @(negedge clk);
    clr_status = 0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    check(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R3 reset state
    check(slice_num == 0, "R3 slice_num", int'(slice_num), 0);
    check(front_sel == 0, "R3 front_sel", int'(front_sel), 0);
    check(load_req == 1, "R3 load_req", int'(load_req), 1);
    check(load_slice == 1, "R3 load_slice", int'(load_slice), 1);
    check(underrun == 0 && drop_cnt == 0 && index_lost == 0, "R3 status",
          int'(underrun) + int'(drop_cnt) + int'(index_lost), 0);
    rst_n = 1;
    index_pulse();

    // R1 / R5 nominal revolutions
    for (int r = 0; r < 2; r++) begin
      int c0, s0;
      c0 = chg_cnt; s0 = swp_cnt;
      steps(CPR);
      index_pulse();
      check(chg_cnt - c0 == NS, "R1 changes per revolution", chg_cnt - c0, NS);
      check(swp_cnt - s0 == NS, "R5 swaps per revolution", swp_cnt - s0, NS);
      check(underrun == 0, "R6 no underrun with fast loader", int'(underrun), 0);
    end

    // R2 early index mid-revolution
    steps(95);
    check(slice_num == 9, "R2 before index", int'(slice_num), 9);
    index_pulse();
    check(slice_num == 0, "R2 index zeroes slice", int'(slice_num), 0);
    steps(SPC - 1);
    check(slice_num == 0, "R2 no boundary before full sector", int'(slice_num), 0);
    step();
    @(negedge clk);
    check(slice_num == 1, "R2 boundary one sector after index", int'(slice_num), 1);
    steps(CPR - SPC);
    index_pulse();

    // R6 slow loader
    ld_delay = 150;
    steps(40);
    check(underrun == 1, "R6 underrun set", int'(underrun), 1);
    check(drop_cnt != 0, "R6 drop counted", int'(drop_cnt), 1);
    ld_delay = 3;
    repeat (200) @(negedge clk);
    clear_pulse();
    check(underrun == 0, "R8 underrun cleared", int'(underrun), 0);
    check(drop_cnt == 0, "R8 drop cleared", int'(drop_cnt), 0);

    // R6 / R7 stalled loader, exact counts
    ld_en = 0;
    steps(2 * SPC);
    clear_pulse();
    steps(3 * SPC);
    @(negedge clk);
    check(drop_cnt == 3, "R6 exact drop count", int'(drop_cnt), 3);
    steps(5 * SPC);
    @(negedge clk);
    check(drop_cnt == 7, "R7 drop saturates", int'(drop_cnt), 7);
    check(underrun == 1, "R6 underrun sticky", int'(underrun), 1);
    clear_pulse();
    ld_en = 1;
    repeat (100) @(negedge clk);
    check(drop_cnt == 0, "R8 clear after saturation", int'(drop_cnt), 0);

    // R9 missing index
    index_pulse();
    steps(2 * CPR - 10);
    @(negedge clk);
    check(index_lost == 0, "R9 not yet lost", int'(index_lost), 0);
    steps(10);
    @(negedge clk);
    check(index_lost == 1, "R9 index lost", int'(index_lost), 1);
    steps(25);
    @(negedge clk);
    check(int'(slice_num) == exp_slice, "R9 slices keep advancing", int'(slice_num), exp_slice);
    clear_pulse();
    check(index_lost == 0, "R8 index_lost cleared", int'(index_lost), 0);
    index_pulse();
    check(exp_q.size() == 0, "R1 all expected changes seen", exp_q.size(), 0);
    finish_up();
  end
endmodule